// File: doc/BRIEF.md
# Two-Phase Frame Ring Pointer Manager

This block keeps the bookkeeping for a circular region of 32-byte frame slots that lives in a shared buffer. The number of slots is a power of two. Each side of the ring moves in two phases. The producer first claims a 16-frame multiframe, which advances the allocation pointer, and later declares the multiframe written, which advances the commit pointer. The consumer first looks at a multiframe, which advances the peek pointer, and later hands it back, which advances the release pointer. A bulk read copies any number of committed frames and moves both read pointers in one step. An empty command drops everything that has been committed but not yet consumed, and keeps the read side aligned to multiframes.

Each granted command returns the slot offset in three forms. These are the absolute frame offset, the same offset as a 32-bit word address for a copy engine, and a multiframe index. The block also reports four occupancy levels at all times. The frame data and the copy engine are outside this block.

Top module: `frame_ring_mgr`

## Requirements
- R1: While `rstN` is low, all four pointers clear, the base becomes 0 and the ring length becomes 2^DEF_LEN_LOG2 (128 frames by default). A sampled `cmdInit` clears all four pointers, loads `initBase` and sets the length to 2^`initLenLog2`.
- R2: The levels are computed modulo the length, with mask = length-1. `lvlAlloc` = (allocation − release) & mask. `lvlValid` = (commit − release) & mask. `lvlUnseen` = (commit − peek) & mask.
- R3: `lvlFree` = (release − allocation − 1) & mask. One slot always stays unused, so `lvlFree` + `lvlAlloc` always equals length − 1.
- R4: A reserve with `lvlFree` ≥ 16 grants offset base + allocation and advances the allocation pointer by 16, modulo the length.
- R5: A commit advances the commit pointer by 16, modulo the length, and produces no grant.
- R6: A peek with `lvlUnseen` ≥ 16 grants offset base + peek and advances the peek pointer by 16.
- R7: A discard advances the release pointer by 16 and produces no grant.
- R8: A reserve with `lvlFree` < 16, or a peek with `lvlUnseen` < 16, raises `refuse` for one cycle, gives no grant and leaves every level unchanged.
- R9: A bulk read grants n = min(`readReq`, `lvlUnseen`, length − peek) frames. It reports n on `grantCount` and offset base + peek, and sets both read pointers to (peek + n) & mask. A result of n = 0 is still granted.
- R10: An empty command sets both read pointers to the commit pointer with its low 4 bits cleared, and produces no grant.
- R11: On a grant, `grantWordAddr` equals `grantOfs` × 8 and `grantMfIdx` equals `grantOfs` / 16. Reserve and peek grants report `grantCount` = 16.
- R12: When several commands are sampled together, only the one of highest priority takes effect. The order is init, empty, commit, discard, reserve, peek, bulk read.
- R13: `grantValid`, `refuse` and the grant fields are registered. They appear in the cycle after the command edge and last one cycle. The levels reflect the new pointers right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdInit | input | 1 | Re-initialise the ring with `initBase` and `initLenLog2` |
| initBase | input | OFS_W | Frame offset of slot 0 |
| initLenLog2 | input | LEN_W | log2 of ring length in frames (5..PTR_W) |
| cmdEmpty | input | 1 | Drop unconsumed committed frames |
| cmdCommit | input | 1 | Commit one multiframe |
| cmdDiscard | input | 1 | Release one multiframe |
| cmdReserve | input | 1 | Claim one multiframe for writing |
| cmdPeek | input | 1 | Look at one multiframe |
| cmdRead | input | 1 | Bulk read of up to `readReq` frames |
| readReq | input | REQ_W | Requested bulk read frame count |
| grantValid | output | 1 | Command granted (one-cycle pulse) |
| refuse | output | 1 | Reserve or peek refused (one-cycle pulse) |
| grantOfs | output | OFS_W | Absolute frame offset of the grant |
| grantWordAddr | output | OFS_W+3 | Grant offset as 32-bit word address |
| grantMfIdx | output | OFS_W-4 | Grant offset as multiframe index |
| grantCount | output | REQ_W | Frames granted |
| lvlAlloc | output | PTR_W | Allocated level |
| lvlValid | output | PTR_W | Valid (committed) level |
| lvlUnseen | output | PTR_W | Committed but not yet peeked |
| lvlFree | output | PTR_W | Unallocated level |

## Verification
The hardest case to reach is a bulk read that the distance to the end of the ring limits, rather than the request or the unseen count. It needs committed data that wraps past slot 0 while the peek pointer sits near the top of the ring. The stimulus sets this up on a 32-frame ring. It alternates reserve/commit pairs with partial bulk reads until the peek pointer rests at slot 24 with 24 frames unseen. A 20-frame request must then return only 8 frames. Refusals are driven with the free level at exactly 15, and priority is checked by pairing commands whose individual effects differ.

// File: rtl/frame_ring_pkg.sv
package frame_ring_pkg;
  localparam int unsigned MF_FRAMES = 16;

  typedef struct packed {
    logic init;
    logic empty;
    logic commit;
    logic discard;
    logic reserve;
    logic peek;
    logic read;
    logic refuse;
  } ring_strobe_t;
endpackage

// File: rtl/frame_ring_ctrl.sv
module frame_ring_ctrl
  import frame_ring_pkg::*;
#(
  parameter int unsigned PTR_W = 10,
  parameter int unsigned REQ_W = 6
) (
  input  logic             cmdInit,
  input  logic             cmdEmpty,
  input  logic             cmdCommit,
  input  logic             cmdDiscard,
  input  logic             cmdReserve,
  input  logic             cmdPeek,
  input  logic             cmdRead,
  input  logic [REQ_W-1:0] readReq,
  input  logic [PTR_W-1:0] freeLvl,
  input  logic [PTR_W-1:0] unseenLvl,
  input  logic [PTR_W:0]   distToEnd,
  output ring_strobe_t     strobe,
  output logic [REQ_W-1:0] readN
);
  localparam int unsigned CW = (PTR_W + 1 > REQ_W) ? PTR_W + 1 : REQ_W;

  logic freeOk, unseenOk;
  logic [CW-1:0] reqW, unseenW, endW, minA, minB;

  assign freeOk   = {1'b0, freeLvl}   >= (PTR_W+1)'(MF_FRAMES);
  assign unseenOk = {1'b0, unseenLvl} >= (PTR_W+1)'(MF_FRAMES);

  assign reqW    = CW'(readReq);
  assign unseenW = CW'(unseenLvl);
  assign endW    = CW'(distToEnd);
  assign minA    = (reqW < unseenW) ? reqW : unseenW;
  assign minB    = (minA < endW) ? minA : endW;

  always_comb begin
    strobe = '0;
    readN  = '0;
    if (cmdInit) begin
      strobe.init = 1'b1;
    end else if (cmdEmpty) begin
      strobe.empty = 1'b1;
    end else if (cmdCommit) begin
      strobe.commit = 1'b1;
    end else if (cmdDiscard) begin
      strobe.discard = 1'b1;
    end else if (cmdReserve) begin
      if (freeOk) strobe.reserve = 1'b1;
      else        strobe.refuse  = 1'b1;
    end else if (cmdPeek) begin
      if (unseenOk) strobe.peek   = 1'b1;
      else          strobe.refuse = 1'b1;
    end else if (cmdRead) begin
      strobe.read = 1'b1;
      readN       = REQ_W'(minB);
    end
  end
endmodule

// File: rtl/frame_ring_dpath.sv
module frame_ring_dpath
  import frame_ring_pkg::*;
#(
  parameter int unsigned PTR_W        = 10,
  parameter int unsigned OFS_W        = 12,
  parameter int unsigned REQ_W        = 6,
  parameter int unsigned LEN_W        = 4,
  parameter int unsigned DEF_LEN_LOG2 = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  ring_strobe_t       strobe,
  input  logic [REQ_W-1:0]   readN,
  input  logic [OFS_W-1:0]   initBase,
  input  logic [LEN_W-1:0]   initLenLog2,
  output logic [PTR_W-1:0]   ringMask,
  output logic [PTR_W:0]     distToEnd,
  output logic               grantValid,
  output logic               refuse,
  output logic [OFS_W-1:0]   grantOfs,
  output logic [OFS_W+2:0]   grantWordAddr,
  output logic [OFS_W-5:0]   grantMfIdx,
  output logic [REQ_W-1:0]   grantCount,
  output logic [PTR_W-1:0]   lvlAlloc,
  output logic [PTR_W-1:0]   lvlValid,
  output logic [PTR_W-1:0]   lvlUnseen,
  output logic [PTR_W-1:0]   lvlFree
);
  localparam logic [PTR_W:0]   ONE_W   = (PTR_W+1)'(1);
  localparam logic [PTR_W-1:0] DEF_MSK = PTR_W'((ONE_W << DEF_LEN_LOG2) - ONE_W);
  localparam logic [PTR_W-1:0] STEP    = PTR_W'(MF_FRAMES);
  localparam logic [PTR_W-1:0] MF_ALGN = ~PTR_W'(MF_FRAMES - 1);

  logic [PTR_W-1:0] wrCommit, wrAlloc, rdRelease, rdPeek;
  logic [OFS_W-1:0] baseOfs;
  logic [PTR_W-1:0] newMask, peekAfterRead;

  assign ringMask  = ringMaskQ;
  logic [PTR_W-1:0] ringMaskQ;

  assign newMask       = PTR_W'((ONE_W << initLenLog2) - ONE_W);
  assign peekAfterRead = (rdPeek + PTR_W'(readN)) & ringMaskQ;
  assign distToEnd     = {1'b0, ringMaskQ} - {1'b0, rdPeek} + ONE_W;

  assign lvlAlloc  = (wrAlloc  - rdRelease) & ringMaskQ;
  assign lvlValid  = (wrCommit - rdRelease) & ringMaskQ;
  assign lvlUnseen = (wrCommit - rdPeek)    & ringMaskQ;
  assign lvlFree   = (rdRelease - wrAlloc - PTR_W'(1)) & ringMaskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCommit  <= '0;
      wrAlloc   <= '0;
      rdRelease <= '0;
      rdPeek    <= '0;
      baseOfs   <= '0;
      ringMaskQ <= DEF_MSK;
    end else if (strobe.init) begin
      wrCommit  <= '0;
      wrAlloc   <= '0;
      rdRelease <= '0;
      rdPeek    <= '0;
      baseOfs   <= initBase;
      ringMaskQ <= newMask;
    end else begin
      if (strobe.empty) begin
        rdRelease <= wrCommit & MF_ALGN;
        rdPeek    <= wrCommit & MF_ALGN;
      end
      if (strobe.commit)  wrCommit  <= (wrCommit + STEP) & ringMaskQ;
      if (strobe.discard) rdRelease <= (rdRelease + STEP) & ringMaskQ;
      if (strobe.reserve) wrAlloc   <= (wrAlloc + STEP) & ringMaskQ;
      if (strobe.peek)    rdPeek    <= (rdPeek + STEP) & ringMaskQ;
      if (strobe.read) begin
        rdPeek    <= peekAfterRead;
        rdRelease <= peekAfterRead;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      refuse     <= 1'b0;
      grantOfs   <= '0;
      grantCount <= '0;
    end else begin
      grantValid <= strobe.reserve | strobe.peek | strobe.read;
      refuse     <= strobe.refuse;
      if (strobe.reserve) begin
        grantOfs   <= baseOfs + OFS_W'(wrAlloc);
        grantCount <= REQ_W'(MF_FRAMES);
      end else if (strobe.peek) begin
        grantOfs   <= baseOfs + OFS_W'(rdPeek);
        grantCount <= REQ_W'(MF_FRAMES);
      end else if (strobe.read) begin
        grantOfs   <= baseOfs + OFS_W'(rdPeek);
        grantCount <= readN;
      end
    end
  end

  assign grantWordAddr = {grantOfs, 3'b000};
  assign grantMfIdx    = grantOfs[OFS_W-1:4];
endmodule

// File: rtl/frame_ring_mgr.sv
module frame_ring_mgr
  import frame_ring_pkg::*;
#(
  parameter int unsigned PTR_W        = 10,
  parameter int unsigned OFS_W        = 12,
  parameter int unsigned REQ_W        = 6,
  parameter int unsigned LEN_W        = 4,
  parameter int unsigned DEF_LEN_LOG2 = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdInit,
  input  logic [OFS_W-1:0] initBase,
  input  logic [LEN_W-1:0] initLenLog2,
  input  logic             cmdEmpty,
  input  logic             cmdCommit,
  input  logic             cmdDiscard,
  input  logic             cmdReserve,
  input  logic             cmdPeek,
  input  logic             cmdRead,
  input  logic [REQ_W-1:0] readReq,
  output logic             grantValid,
  output logic             refuse,
  output logic [OFS_W-1:0] grantOfs,
  output logic [OFS_W+2:0] grantWordAddr,
  output logic [OFS_W-5:0] grantMfIdx,
  output logic [REQ_W-1:0] grantCount,
  output logic [PTR_W-1:0] lvlAlloc,
  output logic [PTR_W-1:0] lvlValid,
  output logic [PTR_W-1:0] lvlUnseen,
  output logic [PTR_W-1:0] lvlFree
);
  ring_strobe_t     strobe;
  logic [REQ_W-1:0] readN;
  logic [PTR_W-1:0] ringMask;
  logic [PTR_W:0]   distToEnd;

  frame_ring_ctrl #(.PTR_W(PTR_W), .REQ_W(REQ_W)) u_ctrl (
    .cmdInit(cmdInit), .cmdEmpty(cmdEmpty), .cmdCommit(cmdCommit),
    .cmdDiscard(cmdDiscard), .cmdReserve(cmdReserve), .cmdPeek(cmdPeek),
    .cmdRead(cmdRead), .readReq(readReq), .freeLvl(lvlFree),
    .unseenLvl(lvlUnseen), .distToEnd(distToEnd), .strobe(strobe), .readN(readN)
  );

  frame_ring_dpath #(
    .PTR_W(PTR_W), .OFS_W(OFS_W), .REQ_W(REQ_W), .LEN_W(LEN_W),
    .DEF_LEN_LOG2(DEF_LEN_LOG2)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .readN(readN),
    .initBase(initBase), .initLenLog2(initLenLog2), .ringMask(ringMask),
    .distToEnd(distToEnd), .grantValid(grantValid), .refuse(refuse),
    .grantOfs(grantOfs), .grantWordAddr(grantWordAddr),
    .grantMfIdx(grantMfIdx), .grantCount(grantCount), .lvlAlloc(lvlAlloc),
    .lvlValid(lvlValid), .lvlUnseen(lvlUnseen), .lvlFree(lvlFree)
  );
endmodule

// File: rtl/frame_ring_mgr_chk.sv
module frame_ring_mgr_chk #(
  parameter int unsigned PTR_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdInit,
  input logic             cmdEmpty,
  input logic             cmdCommit,
  input logic             cmdDiscard,
  input logic             cmdReserve,
  input logic             grantValid,
  input logic             refuse,
  input logic [PTR_W-1:0] ringMask,
  input logic [PTR_W-1:0] lvlAlloc,
  input logic [PTR_W-1:0] lvlValid,
  input logic [PTR_W-1:0] lvlUnseen,
  input logic [PTR_W-1:0] lvlFree
);
  // R3: one slot always stays unused
  p_free_alloc_r3: assert property (@(posedge clk) disable iff (!rstN)
    (PTR_W+1)'(lvlFree) + (PTR_W+1)'(lvlAlloc) == (PTR_W+1)'(ringMask));

  // R8: a refusal leaves every level where it was
  p_refuse_still_r8: assert property (@(posedge clk) disable iff (!rstN)
    refuse |-> ($stable(lvlAlloc) && $stable(lvlValid) &&
                $stable(lvlUnseen) && $stable(lvlFree)));

  // R13: grant and refuse never coincide
  p_grant_excl_r13: assert property (@(posedge clk) disable iff (!rstN)
    !(grantValid && refuse));

  // R1: init clears all levels
  p_init_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmdInit |=> (lvlAlloc == '0 && lvlValid == '0 && lvlUnseen == '0));

  // R4: a lone reserve with room is granted and grows the allocation by 16
  p_reserve_grant_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReserve && !cmdInit && !cmdEmpty && !cmdCommit && !cmdDiscard &&
     lvlFree >= PTR_W'(16))
    |=> (grantValid && lvlAlloc == (($past(lvlAlloc) + PTR_W'(16)) & ringMask)));
endmodule

bind frame_ring_mgr frame_ring_mgr_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdInit(cmdInit), .cmdEmpty(cmdEmpty),
  .cmdCommit(cmdCommit), .cmdDiscard(cmdDiscard), .cmdReserve(cmdReserve),
  .grantValid(grantValid), .refuse(refuse), .ringMask(ringMask),
  .lvlAlloc(lvlAlloc), .lvlValid(lvlValid), .lvlUnseen(lvlUnseen),
  .lvlFree(lvlFree)
);

// File: tb/sim_frame_ring_mgr.sv
module sim_frame_ring_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int PTR_W = 10, OFS_W = 12, REQ_W = 6, LEN_W = 4;
  localparam int NV = 27;

  // cmd bits: [6]init [5]empty [4]commit [3]discard [2]reserve [1]peek [0]read
  typedef struct packed {
    logic [6:0]       cmd;
    logic [REQ_W-1:0] req;
    logic             g;
    logic             r;
    logic [OFS_W-1:0] ofs;
    logic [REQ_W-1:0] cnt;
    logic [PTR_W-1:0] a, v, u, f;
  } vec_t;

  // ring of 32 frames at base 256
  localparam vec_t VECS [NV] = '{
    '{7'b1000000, 6'd0,  1'b0, 1'b0, 12'd0,   6'd0,  10'd0,  10'd0,  10'd0,  10'd31},
    '{7'b0000100, 6'd0,  1'b1, 1'b0, 12'd256, 6'd16, 10'd16, 10'd0,  10'd0,  10'd15},
    '{7'b0000100, 6'd0,  1'b0, 1'b1, 12'd0,   6'd0,  10'd16, 10'd0,  10'd0,  10'd15},
    '{7'b0000010, 6'd0,  1'b0, 1'b1, 12'd0,   6'd0,  10'd16, 10'd0,  10'd0,  10'd15},
    '{7'b0010000, 6'd0,  1'b0, 1'b0, 12'd0,   6'd0,  10'd16, 10'd16, 10'd16, 10'd15},
    '{7'b0000010, 6'd0,  1'b1, 1'b0, 12'd256, 6'd16, 10'd16, 10'd16, 10'd0,  10'd15},
    '{7'b0001000, 6'd0,  1'b0, 1'b0, 12'd0,   6'd0,  10'd0,  10'd0,  10'd0,  10'd31},
    '{7'b0000100, 6'd0,  1'b1, 1'b0, 12'd272, 6'd16, 10'd16, 10'd0,  10'd0,  10'd15},
    '{7'b0010000, 6'd0,  1'b0, 1'b0, 12'd0,   6'd0,  10'd16, 10'd16, 10'd16, 10'd15},
    '{7'b0000001, 6'd20, 1'b1, 1'b0, 12'd272, 6'd16, 10'd0,  10'd0,  10'd0,  10'd31},
    '{7'b0000100, 6'd0,  1'b1, 1'b0, 12'd256, 6'd16, 10'd16, 10'd0,  10'd0,  10'd15},
    '{7'b0010000, 6'd0,  1'b0, 1'b0, 12'd0,   6'd0,  10'd16, 10'd16, 10'd16, 10'd15},
    '{7'b0000001, 6'd5,  1'b1, 1'b0, 12'd256, 6'd5,  10'd11, 10'd11, 10'd11, 10'd20},
    '{7'b0100000, 6'd0,  1'b0, 1'b0, 12'd0,   6'd0,  10'd0,  10'd0,  10'd0,  10'd31},
    '{7'b0000110, 6'd0,  1'b1, 1'b0, 12'd272, 6'd16, 10'd16, 10'd0,  10'd0,  10'd15},
    '{7'b0010010, 6'd0,  1'b0, 1'b0, 12'd0,   6'd0,  10'd16, 10'd16, 10'd16, 10'd15},
    '{7'b0000001, 6'd0,  1'b1, 1'b0, 12'd272, 6'd0,  10'd16, 10'd16, 10'd16, 10'd15},
    '{7'b0110100, 6'd0,  1'b0, 1'b0, 12'd0,   6'd0,  10'd0,  10'd0,  10'd0,  10'd31},
    '{7'b0000100, 6'd0,  1'b1, 1'b0, 12'd256, 6'd16, 10'd16, 10'd0,  10'd0,  10'd15},
    '{7'b0010000, 6'd0,  1'b0, 1'b0, 12'd0,   6'd0,  10'd16, 10'd16, 10'd16, 10'd15},
    '{7'b0000001, 6'd16, 1'b1, 1'b0, 12'd256, 6'd16, 10'd0,  10'd0,  10'd0,  10'd31},
    '{7'b0000100, 6'd0,  1'b1, 1'b0, 12'd272, 6'd16, 10'd16, 10'd0,  10'd0,  10'd15},
    '{7'b0010000, 6'd0,  1'b0, 1'b0, 12'd0,   6'd0,  10'd16, 10'd16, 10'd16, 10'd15},
    '{7'b0000001, 6'd8,  1'b1, 1'b0, 12'd272, 6'd8,  10'd8,  10'd8,  10'd8,  10'd23},
    '{7'b0000100, 6'd0,  1'b1, 1'b0, 12'd256, 6'd16, 10'd24, 10'd8,  10'd8,  10'd7},
    '{7'b0010000, 6'd0,  1'b0, 1'b0, 12'd0,   6'd0,  10'd24, 10'd24, 10'd24, 10'd7},
    '{7'b0000001, 6'd20, 1'b1, 1'b0, 12'd280, 6'd8,  10'd16, 10'd16, 10'd16, 10'd15}
  };

  localparam string TAGS [NV] = '{
    "R1 init", "R4 reserve", "R8 reserve refused", "R8 peek refused",
    "R5 commit", "R6 peek", "R7 discard", "R4 reserve wraps", "R5 commit wraps",
    "R9 read clamped by unseen", "R4 reserve", "R5 commit", "R9 partial read",
    "R10 empty", "R12 reserve beats peek", "R12 commit beats peek",
    "R9 zero-length read", "R12 empty beats commit/reserve", "R4 reserve",
    "R5 commit", "R9 full read", "R4 reserve", "R5 commit", "R9 read 8",
    "R3 reserve near full", "R2 commit", "R9 read clamped by ring end"
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdInit = 0, cmdEmpty = 0, cmdCommit = 0, cmdDiscard = 0;
  logic cmdReserve = 0, cmdPeek = 0, cmdRead = 0;
  logic [OFS_W-1:0] initBase = 12'd256;
  logic [LEN_W-1:0] initLenLog2 = 4'd5;
  logic [REQ_W-1:0] readReq = '0;
  logic grantValid, refuse;
  logic [OFS_W-1:0] grantOfs;
  logic [OFS_W+2:0] grantWordAddr;
  logic [OFS_W-5:0] grantMfIdx;
  logic [REQ_W-1:0] grantCount;
  logic [PTR_W-1:0] lvlAlloc, lvlValid, lvlUnseen, lvlFree;

  int nChecks = 0, nFails = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_ring_mgr u0 (
    .clk(clk), .rstN(rstN), .cmdInit(cmdInit), .initBase(initBase),
    .initLenLog2(initLenLog2), .cmdEmpty(cmdEmpty), .cmdCommit(cmdCommit),
    .cmdDiscard(cmdDiscard), .cmdReserve(cmdReserve), .cmdPeek(cmdPeek),
    .cmdRead(cmdRead), .readReq(readReq), .grantValid(grantValid),
    .refuse(refuse), .grantOfs(grantOfs), .grantWordAddr(grantWordAddr),
    .grantMfIdx(grantMfIdx), .grantCount(grantCount), .lvlAlloc(lvlAlloc),
    .lvlValid(lvlValid), .lvlUnseen(lvlUnseen), .lvlFree(lvlFree)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] c, input logic [REQ_W-1:0] rq);
    {cmdInit, cmdEmpty, cmdCommit, cmdDiscard, cmdReserve, cmdPeek, cmdRead} = c;
    readReq = rq;
  endtask

  task automatic checkLevels(input string tag, input logic [PTR_W-1:0] a, v, u, f);
    chk(tag, "lvlAlloc R2", 32'(lvlAlloc), 32'(a));
    chk(tag, "lvlValid R2", 32'(lvlValid), 32'(v));
    chk(tag, "lvlUnseen R2", 32'(lvlUnseen), 32'(u));
    chk(tag, "lvlFree R3", 32'(lvlFree), 32'(f));
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, default 128-frame ring
    chk("R1 reset", "grantValid", 32'(grantValid), 0);
    chk("R1 reset", "refuse", 32'(refuse), 0);
    checkLevels("R1 reset", 10'd0, 10'd0, 10'd0, 10'd127);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].cmd, VECS[i].req);
      @(negedge clk);
      chk(TAGS[i], "grantValid R13", 32'(grantValid), 32'(VECS[i].g));
      chk(TAGS[i], "refuse R8", 32'(refuse), 32'(VECS[i].r));
      if (VECS[i].g) begin
        chk(TAGS[i], "grantOfs", 32'(grantOfs), 32'(VECS[i].ofs));
        chk(TAGS[i], "grantCount", 32'(grantCount), 32'(VECS[i].cnt));
        chk(TAGS[i], "grantWordAddr R11", 32'(grantWordAddr), 32'(VECS[i].ofs) * 8);
        chk(TAGS[i], "grantMfIdx R11", 32'(grantMfIdx), 32'(VECS[i].ofs) / 16);
      end
      checkLevels(TAGS[i], VECS[i].a, VECS[i].v, VECS[i].u, VECS[i].f);
    end

    // R13: grant is a one-cycle pulse
    drive(7'b0, '0);
    @(negedge clk);
    chk("R13 pulse ends", "grantValid", 32'(grantValid), 0);
    checkLevels("R13 idle hold", 10'd16, 10'd16, 10'd16, 10'd15);

    // R8: refuse lasts one cycle, levels untouched
    drive(7'b0000100, '0);
    @(negedge clk);
    chk("R8 refuse", "refuse", 32'(refuse), 1);
    drive(7'b0, '0);
    @(negedge clk);
    chk("R8 refuse pulse ends", "refuse", 32'(refuse), 0);
    checkLevels("R8 no change", 10'd16, 10'd16, 10'd16, 10'd15);

    // R1: mid-run reset returns the default ring
    rstN = 1'b0;
    @(negedge clk);
    checkLevels("R1 reset again", 10'd0, 10'd0, 10'd0, 10'd127);
    rstN = 1'b1;
    drive(7'b0000100, '0);
    @(negedge clk);
    chk("R1 default base", "grantOfs", 32'(grantOfs), 0);
    checkLevels("R1 default length", 10'd16, 10'd0, 10'd0, 10'd111);
    drive(7'b0, '0);
    @(negedge clk);

    done = 1'b1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule